// File: doc/BRIEF.md
# Thread Criticality Score Accumulator

This block ranks a fixed set of hardware threads by how much each one has contributed to the forward progress of the whole group. Time is divided into equal-length measurement intervals. At each interval boundary the surrounding logic pulses an end-of-interval strobe and presents, side by side, the number of instructions each thread retired during that interval. All threads see the same cycle count, so the retired count stands for that thread's IPC.

For every thread the block computes that thread's fraction of the interval's total, as an unsigned fixed-point value with 16 fractional bits. It adds the fraction to the thread's running score. One serial divider handles the threads in turn, lowest index first. The block always presents the index of the thread with the largest accumulated score. A valid flag says that every fraction from the most recent interval has been added. A clear input drops all scores back to zero, so a new ranking epoch can begin.

Top module: `crit_score_unit`

## Requirements
- R1: After reset `best_vld` is 0 and `best_idx` is 0, and every score is zero.
- R2: For an accepted interval with a nonzero total S, thread i gets the fraction floor(c_i * 65536 / S), where 65536 stands for 1.0. That fraction is added to the thread's score.
- R3: Scores add up over every interval accepted since the last reset or clear, so the ranking reflects all intervals together and not only the latest one.
- R4: `best_idx` names the thread with the largest score. When several threads share the top score, the lowest index among them is named.
- R5: An interval whose counts are all zero adds nothing to any score. `best_vld` is 1 in the cycle after that interval is accepted.
- R6: A score that would pass 2^ACC_W - 1 stays at 2^ACC_W - 1 and does not wrap.
- R7: While `clr` is high, every score is set to zero and any division in progress is abandoned. In the cycle after, `best_vld` is 0 and `best_idx` is 0.
- R8: An interval with a nonzero total is accepted on the clock edge where `iv_end` is high. `best_vld` is 0 after that edge and returns to 1 exactly N_THR*(FRAC_W+1) edges later, which is 68 with the default parameters.
- R9: An `iv_end` pulse that arrives while a division is in progress is ignored. The counts offered with it have no effect on any score, and the timing of the interval already in progress does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero all scores and abandon work in progress |
| iv_end | input | 1 | End-of-interval strobe; counts are sampled when it is accepted |
| iv_counts | input | N_THR*CNT_W | Retired-instruction counts; thread i occupies bits [i*CNT_W +: CNT_W] |
| best_idx | output | $clog2(N_THR) | Index of the thread with the highest score |
| best_vld | output | 1 | High when the latest interval has been fully added |

## Verification
The hardest situation to reach from the ports is the saturation limit: a score has to climb all the way to 2^ACC_W - 1. The stimulus gets there by feeding sixteen intervals in which only thread 0 retires instructions, so it earns exactly 1.0 each time. It then feeds one interval credited only to thread 1. A wrapping accumulator would fall back to zero and hand the top rank to thread 1, while a saturating one keeps thread 0 on top. A strobe that lands in the middle of a division is also placed on purpose, a few cycles into a run, with counts that would reverse the ranking if they were taken.

// File: rtl/crit_pkg.sv
package crit_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } crit_state_e;
endpackage

// File: rtl/crit_serdiv.sv
module crit_serdiv #(
  parameter int NUM_W  = 16,
  parameter int DEN_W  = 18,
  parameter int FRAC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kill,
  input  logic                start,
  input  logic [NUM_W-1:0]    num,
  input  logic [DEN_W-1:0]    den,
  output logic                last,
  output logic [FRAC_W:0]     quo_next
);
  localparam int REM_W = DEN_W + 1;
  localparam int Q_W   = FRAC_W + 1;
  localparam int STP_W = $clog2(FRAC_W + 1);

  logic [REM_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic [Q_W-1:0]   q;
  logic [STP_W-1:0] stp;
  logic             run;

  logic [REM_W-1:0] trial, rem_nxt;
  logic             ge;

  // One restoring step: the first step takes the integer bit, the later ones the fraction bits.
  always_comb begin
    trial    = (stp == '0) ? rem : {rem[REM_W-2:0], 1'b0};
    ge       = trial >= {1'b0, den_q};
    rem_nxt  = ge ? (trial - {1'b0, den_q}) : trial;
    quo_next = {q[Q_W-2:0], ge};
  end

  assign last = run && (stp == STP_W'(FRAC_W));

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      run   <= 1'b0;
      rem   <= '0;
      den_q <= '0;
      q     <= '0;
      stp   <= '0;
    end else if (start) begin
      run   <= 1'b1;
      rem   <= REM_W'(num);
      den_q <= den;
      q     <= '0;
      stp   <= '0;
    end else if (run) begin
      rem <= rem_nxt;
      q   <= quo_next;
      if (last) run <= 1'b0;
      else      stp <= stp + 1'b1;
    end
  end
endmodule

// File: rtl/crit_argmax.sv
module crit_argmax #(
  parameter int N_THR = 4,
  parameter int ACC_W = 20,
  localparam int IDX_W = $clog2(N_THR)
) (
  input  logic [N_THR*ACC_W-1:0] acc_flat,
  output logic [IDX_W-1:0]       idx
);
  logic [ACC_W-1:0] top_val;

  // Strict greater-than keeps the earliest index on ties.
  always_comb begin
    idx     = '0;
    top_val = acc_flat[0 +: ACC_W];
    for (int i = 1; i < N_THR; i++) begin
      if (acc_flat[i*ACC_W +: ACC_W] > top_val) begin
        top_val = acc_flat[i*ACC_W +: ACC_W];
        idx     = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/crit_score_unit.sv
module crit_score_unit #(
  parameter int N_THR  = 4,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int ACC_W  = 20,
  localparam int IDX_W = $clog2(N_THR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   iv_end,
  input  logic [N_THR*CNT_W-1:0] iv_counts,
  output logic [IDX_W-1:0]       best_idx,
  output logic                   best_vld
);
  import crit_pkg::*;

  localparam int SUM_W = CNT_W + IDX_W;
  localparam int SHR_W = FRAC_W + 1;

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a,
                                               input logic [SHR_W-1:0] b);
    logic [ACC_W:0] s;
    s = {1'b0, a} + (ACC_W+1)'(b);
    return s[ACC_W] ? {ACC_W{1'b1}} : s[ACC_W-1:0];
  endfunction

  function automatic logic [SUM_W-1:0] total(input logic [N_THR*CNT_W-1:0] v);
    logic [SUM_W-1:0] t;
    t = '0;
    for (int i = 0; i < N_THR; i++) t = t + SUM_W'(v[i*CNT_W +: CNT_W]);
    return t;
  endfunction

  crit_state_e             st;
  logic [IDX_W-1:0]        thr;
  logic [SUM_W-1:0]        sum_q;
  logic [N_THR*CNT_W-1:0]  cnt_q;
  logic [N_THR*ACC_W-1:0]  acc_flat;
  logic                    vld;

  // Named events for the checker.
  logic [SUM_W-1:0] sum_in;
  logic             accept, accept_zero, accept_nz;
  logic             div_last, add_ev, last_thr, div_start;
  logic [IDX_W-1:0] nxt_idx;
  logic [CNT_W-1:0] div_num;
  logic [SUM_W-1:0] div_den;
  logic [SHR_W-1:0] share;

  assign sum_in      = total(iv_counts);
  assign accept      = iv_end && (st == ST_IDLE) && !clr;
  assign accept_zero = accept && (sum_in == '0);
  assign accept_nz   = accept && (sum_in != '0);
  assign add_ev      = div_last && !clr && (st == ST_RUN);
  assign last_thr    = (thr == IDX_W'(N_THR - 1));
  assign nxt_idx     = last_thr ? thr : thr + 1'b1;
  assign div_start   = accept_nz || (add_ev && !last_thr);
  assign div_num     = accept_nz ? iv_counts[0 +: CNT_W] : cnt_q[nxt_idx*CNT_W +: CNT_W];
  assign div_den     = accept_nz ? sum_in : sum_q;

  crit_serdiv #(.NUM_W(CNT_W), .DEN_W(SUM_W), .FRAC_W(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .kill     (clr),
    .start    (div_start),
    .num      (div_num),
    .den      (div_den),
    .last     (div_last),
    .quo_next (share)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st    <= ST_IDLE;
      thr   <= '0;
      sum_q <= '0;
      cnt_q <= '0;
      vld   <= 1'b0;
    end else if (accept_zero) begin
      vld <= 1'b1;
    end else if (accept_nz) begin
      st    <= ST_RUN;
      thr   <= '0;
      sum_q <= sum_in;
      cnt_q <= iv_counts;
      vld   <= 1'b0;
    end else if (add_ev) begin
      if (last_thr) begin
        st  <= ST_IDLE;
        vld <= 1'b1;
      end else begin
        thr <= nxt_idx;
      end
    end
  end

  for (genvar g = 0; g < N_THR; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        acc_flat[g*ACC_W +: ACC_W] <= '0;
      else if (add_ev && (thr == IDX_W'(g)))
        acc_flat[g*ACC_W +: ACC_W] <= sat_add(acc_flat[g*ACC_W +: ACC_W], share);
    end
  end

  crit_argmax #(.N_THR(N_THR), .ACC_W(ACC_W)) u_max (
    .acc_flat (acc_flat),
    .idx      (best_idx)
  );

  assign best_vld = vld;
endmodule

// File: rtl/crit_score_chk.sv
module crit_score_chk #(
  parameter int N_THR  = 4,
  parameter int FRAC_W = 16,
  parameter int ACC_W  = 20,
  localparam int IDX_W = $clog2(N_THR),
  localparam int SHR_W = FRAC_W + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clr,
  input logic                   accept_zero,
  input logic                   accept_nz,
  input logic                   add_ev,
  input logic [SHR_W-1:0]       share,
  input logic [N_THR*ACC_W-1:0] acc_flat,
  input logic [IDX_W-1:0]       best_idx,
  input logic                   best_vld
);
  assert_share_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    add_ev |-> (share <= SHR_W'(1 << FRAC_W)));

  assert_zero_interval_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_zero |=> (best_vld && (acc_flat == $past(acc_flat))));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((acc_flat == '0) && !best_vld));

  assert_stale_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_nz |=> !best_vld);

  for (genvar g = 0; g < N_THR; g++) begin : g_mono
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (acc_flat[g*ACC_W +: ACC_W] >= $past(acc_flat[g*ACC_W +: ACC_W])));
  end

  // R4: no score exceeds the named one, and no earlier index equals it.
  always_comb begin
    if (rst_n) begin
      for (int i = 0; i < N_THR; i++) begin
        assert_rank_R4: assert (
          (acc_flat[i*ACC_W +: ACC_W] < acc_flat[best_idx*ACC_W +: ACC_W]) ||
          ((acc_flat[i*ACC_W +: ACC_W] == acc_flat[best_idx*ACC_W +: ACC_W]) &&
           (IDX_W'(i) >= best_idx)));
      end
    end
  end
endmodule

bind crit_score_unit crit_score_chk #(.N_THR(N_THR), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .accept_zero (accept_zero),
  .accept_nz   (accept_nz),
  .add_ev      (add_ev),
  .share       (share),
  .acc_flat    (acc_flat),
  .best_idx    (best_idx),
  .best_vld    (best_vld)
);

// File: tb/sim_crit_score_unit.sv
module sim_crit_score_unit;
  localparam int N_THR  = 4;
  localparam int CNT_W  = 16;
  localparam int FRAC_W = 16;
  localparam int ACC_W  = 20;
  localparam int LAT    = N_THR * (FRAC_W + 1);
  localparam int ROWS   = 7;
  // counts for threads 0..3, then expected best index after cumulative scoring
  localparam int TBL [ROWS][5] = '{
    '{100, 200, 300, 400, 3},
    '{900,   0,   0, 100, 0},
    '{  0, 500, 500,   0, 0},
    '{  0,   0,   3,   1, 2},
    '{  0,   0,   0,   0, 2},
    '{  7,   7,   0,   0, 2},
    '{  1,   1,   0,   0, 0}
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   clr = 1'b0;
  logic                   iv_end = 1'b0;
  logic [N_THR*CNT_W-1:0] iv_counts = '0;
  logic [1:0]             best_idx;
  logic                   best_vld;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  crit_score_unit #(.N_THR(N_THR), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .iv_end(iv_end), .iv_counts(iv_counts),
    .best_idx(best_idx), .best_vld(best_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  function automatic logic [N_THR*CNT_W-1:0] pack(input int c0, c1, c2, c3);
    return {CNT_W'(c3), CNT_W'(c2), CNT_W'(c1), CNT_W'(c0)};
  endfunction

  // Offer one interval, return best_vld just after the accept edge and the edge count until it is 1.
  task automatic run_iv(input int c0, c1, c2, c3, output bit vld_after, output int lat);
    @(negedge clk);
    iv_counts = pack(c0, c1, c2, c3);
    iv_end = 1'b1;
    @(posedge clk);
    @(negedge clk);
    iv_end = 1'b0;
    vld_after = best_vld;
    lat = 0;
    while (!best_vld && lat < 2000) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    bit va;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(best_vld == 1'b0, "R1 vld", best_vld, 0);
    check(best_idx == 2'd0, "R1 idx", best_idx, 0);

    // R2 R3 R4 R5 R8: table of cumulative intervals
    for (int r = 0; r < ROWS; r++) begin
      run_iv(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], va, lat);
      if (TBL[r][0] + TBL[r][1] + TBL[r][2] + TBL[r][3] == 0) begin
        check(va == 1'b1, "R5 vld next cycle", va, 1);
        check(lat == 0, "R5 latency", lat, 0);
      end else begin
        check(va == 1'b0, "R8 stale after accept", va, 0);
        check(lat == LAT, "R8 latency", lat, LAT);
      end
      check(best_idx == 2'(TBL[r][4]), "R2/R3 ranking", best_idx, TBL[r][4]);
    end

    // R7: clear
    pulse_clr();
    check(best_vld == 1'b0, "R7 vld", best_vld, 0);
    check(best_idx == 2'd0, "R7 idx", best_idx, 0);

    // R4: tie between threads 1 and 3 names thread 1
    run_iv(0, 5, 0, 5, va, lat);
    check(best_idx == 2'd1, "R4 tie", best_idx, 1);

    // R9: strobe mid-run with reversing counts is ignored
    pulse_clr();
    @(negedge clk);
    iv_counts = pack(0, 0, 0, 9);
    iv_end = 1'b1;
    @(posedge clk);
    @(negedge clk);
    iv_end = 1'b0;
    lat = 0;
    repeat (5) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    iv_counts = pack(9, 0, 0, 0);
    iv_end = 1'b1;
    @(posedge clk);
    @(negedge clk);
    iv_end = 1'b0;
    lat++;
    while (!best_vld && lat < 2000) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    check(lat == LAT, "R9 latency unchanged", lat, LAT);
    check(best_idx == 2'd3, "R9 ignored counts", best_idx, 3);
    repeat (3) @(negedge clk);
    check(best_vld == 1'b1 && best_idx == 2'd3, "R9 no second run", best_idx, 3);

    // R6: saturate thread 0, then credit thread 1 once
    pulse_clr();
    for (int k = 0; k < 16; k++) run_iv(9, 0, 0, 0, va, lat);
    check(best_idx == 2'd0, "R6 before", best_idx, 0);
    run_iv(0, 9, 0, 0, va, lat);
    check(best_idx == 2'd0, "R6 saturation held", best_idx, 0);

    finish_run();
  end
endmodule